// File: doc/BRIEF.md
# Extension Register Write Legalizer

This block owns the register that advertises which instruction-set extensions a hart currently has enabled, and it screens every attempted write to it. A write arrives as a one-cycle strobe with a proposed value. The block either rejects the write outright, leaving the register untouched, or turns it into a legal value and stores that. The rejections are: writes not permitted at all, writes that name no base integer set, and writes that ask for the embedded base. A legal value is formed by keeping only the extensions this hart supports and this design can implement, and then by dropping extensions whose prerequisites are missing.

When the stored value actually changes, the block raises a single-cycle flush pulse. Downstream logic that caches decoded instructions uses this pulse to invalidate them. A write that leaves the value unchanged produces no pulse. The base-width field in the two most significant bits is never changed by a write. Each extension letter sits at bit (letter minus 'A'), so A is bit 0 and Z is bit 25.

Top module: `ext_cfg_legalizer`

## Requirements
- R1: Out of reset, `cfgValue` equals the `RESET_VAL` parameter (default 0x4014112D: base field 01 with A, C, D, F, I, M, S, U), and `flushPulse` is low.
- R2: A write strobe with `featWrEn` low leaves `cfgValue` unchanged and produces no flush.
- R3: A write whose proposed value has both bit 8 (I) and bit 4 (E) clear is dropped.
- R4: A write whose proposed value has bit 4 (E) set is dropped, whatever else it holds.
- R5: An accepted write stores the proposed value ANDed with `hartMask` and with the implementable set {A bit 0, C bit 2, D bit 3, E bit 4, F bit 5, I bit 8, M bit 12, S bit 18, U bit 20}. Every other bit below the base field reads zero.
- R6: If bit 3 (D) survives masking while bit 5 (F) does not, D is cleared.
- R7: If `nextPcLow` is nonzero, bit 2 (C) is cleared in the stored value.
- R8: Bits XLEN-1 and XLEN-2 (the base-width field) keep their current value on every write.
- R9: `flushPulse` is high for exactly the cycle in which `cfgValue` first shows a new value. It stays low when an accepted write produces the value already stored.
- R10: An accepted write presented at clock edge N appears on `cfgValue` right after edge N, one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe, one cycle per write |
| wrData | input | XLEN | Proposed register value |
| hartMask | input | XLEN | Extensions this hart supports |
| featWrEn | input | 1 | The register is writable when high |
| nextPcLow | input | 2 | Low two bits of the next instruction address |
| cfgValue | output | XLEN | Stored extension register |
| flushPulse | output | 1 | One-cycle pulse on a change of `cfgValue` |

## Verification
Some properties are checked every cycle by assertions. The stored value must never hold an unimplementable bit or D without F. The base field never moves. The flush pulse coincides exactly with a change of the stored value. Each rejection condition (write disabled, no base, embedded base) leaves the value stable. Other behaviour can only be shown by the bench's scenarios, compared against its own model. This covers the exact legalized value under chosen masks, clearing C when the next address is misaligned, the reset default, and the absence of a flush when an identical value is rewritten.

// File: rtl/ext_cfg_pkg.sv
package ext_cfg_pkg;

  // Bit index of each extension letter: letter minus 'A'.
  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // commit the candidate value
    logic stripC;  // next address misaligned: drop compressed
  } cfg_strobe_t;

endpackage

// File: rtl/ext_cfg_ctrl.sv
module ext_cfg_ctrl
  import ext_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrValid,
  input  logic        featWrEn,
  input  logic        propI,
  input  logic        propE,
  input  logic [1:0]  nextPcLow,
  input  logic        candDiffers,
  output cfg_strobe_t strobes,
  output logic        flushPulse
);

  logic accept;
  logic flushQ;

  // A write survives only if enabled and it names the full base set.
  assign accept = wrValid && featWrEn && propI && !propE;

  always_comb begin
    strobes.load   = accept && candDiffers;
    strobes.stripC = (nextPcLow != 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flushQ <= 1'b0;
    else        flushQ <= strobes.load;
  end

  assign flushPulse = flushQ;

  AST_DROP_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !featWrEn) |-> !strobes.load); // R2

  AST_DROP_EMBEDDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && propE) |-> !strobes.load); // R4

endmodule

// File: rtl/ext_cfg_datapath.sv
module ext_cfg_datapath
  import ext_cfg_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] hartMask,
  input  cfg_strobe_t     strobes,
  output logic [XLEN-1:0] cfgValue,
  output logic            candDiffers
);

  localparam int LOW_W = XLEN - 2;

  function automatic logic [XLEN-1:0] buildImpl();
    logic [XLEN-1:0] m;
    m = '0;
    m[BIT_A] = 1'b1; m[BIT_C] = 1'b1; m[BIT_D] = 1'b1;
    m[BIT_E] = 1'b1; m[BIT_F] = 1'b1; m[BIT_I] = 1'b1;
    m[BIT_M] = 1'b1; m[BIT_S] = 1'b1; m[BIT_U] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] IMPL_MASK = buildImpl();

  logic [XLEN-1:0]  regQ;
  logic [XLEN-1:0]  masked;
  logic [LOW_W-1:0] lowFields;
  logic [XLEN-1:0]  candidate;

  // Per-bit filtering against both masks.
  for (genvar b = 0; b < XLEN; b++) begin : g_mask
    assign masked[b] = wrData[b] & hartMask[b] & IMPL_MASK[b];
  end

  always_comb begin
    lowFields = masked[LOW_W-1:0];
    if (!lowFields[BIT_F]) lowFields[BIT_D] = 1'b0;
    if (strobes.stripC)    lowFields[BIT_C] = 1'b0;
    candidate   = {regQ[XLEN-1:XLEN-2], lowFields};
    candDiffers = (candidate != regQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            regQ <= RESET_VAL;
    else if (strobes.load) regQ <= candidate;
  end

  assign cfgValue = regQ;

  AST_ONLY_IMPLEMENTED: assert property (@(posedge clk) disable iff (!rst_n)
    (regQ[LOW_W-1:0] & ~IMPL_MASK[LOW_W-1:0]) == '0); // R5

  AST_D_NEEDS_F: assert property (@(posedge clk) disable iff (!rst_n)
    regQ[BIT_D] |-> regQ[BIT_F]); // R6

  AST_BASE_FIELD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(regQ[XLEN-1:XLEN-2])); // R8

endmodule

// File: rtl/ext_cfg_legalizer.sv
module ext_cfg_legalizer
  import ext_cfg_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = {2'b01, {(XLEN-32){1'b0}}, 30'h0014112D}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrValid,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] hartMask,
  input  logic            featWrEn,
  input  logic [1:0]      nextPcLow,
  output logic [XLEN-1:0] cfgValue,
  output logic            flushPulse
);

  cfg_strobe_t strobes;
  logic        candDiffers;

  ext_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrValid    (wrValid),
    .featWrEn   (featWrEn),
    .propI      (wrData[BIT_I]),
    .propE      (wrData[BIT_E]),
    .nextPcLow  (nextPcLow),
    .candDiffers(candDiffers),
    .strobes    (strobes),
    .flushPulse (flushPulse)
  );

  ext_cfg_datapath #(
    .XLEN     (XLEN),
    .RESET_VAL(RESET_VAL)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrData     (wrData),
    .hartMask   (hartMask),
    .strobes    (strobes),
    .cfgValue   (cfgValue),
    .candDiffers(candDiffers)
  );

  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !featWrEn) |=> $stable(cfgValue)); // R2

  AST_NO_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrData[BIT_I] && !wrData[BIT_E]) |=> $stable(cfgValue)); // R3

  AST_EMBEDDED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrData[BIT_E]) |=> $stable(cfgValue)); // R4

  AST_CHANGE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgValue != $past(cfgValue)) |-> flushPulse); // R9

  AST_FLUSH_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    flushPulse |-> (cfgValue != $past(cfgValue))); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrValid |=> $stable(cfgValue)); // R10

endmodule

// File: tb/sim_ext_cfg_legalizer.sv
module sim_ext_cfg_legalizer;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] RST_VAL = 32'h4014112D;
  localparam logic [31:0] IMPL    = 32'h0014113D;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wrValid;
  logic [XLEN-1:0] wrData;
  logic [XLEN-1:0] hartMask;
  logic            featWrEn;
  logic [1:0]      nextPcLow;
  logic [XLEN-1:0] cfgValue;
  logic            flushPulse;

  int checks = 0;
  int fails  = 0;
  logic [31:0] modelReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_cfg_legalizer u0 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .hartMask(hartMask), .featWrEn(featWrEn), .nextPcLow(nextPcLow),
    .cfgValue(cfgValue), .flushPulse(flushPulse)
  );

  function automatic logic [31:0] legalize(logic [31:0] cur, logic [31:0] d,
      logic [31:0] m, logic en, logic [1:0] pc);
    logic [31:0] v;
    if (!en || !(d[8] || d[4]) || d[4]) return cur;
    v = d & m & IMPL;
    if (v[3] && !v[5]) v[3] = 1'b0;
    if (pc != 2'b00) v[2] = 1'b0;
    v[31:30] = cur[31:30];
    return v;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyWrite(input logic [31:0] d, input logic [31:0] m,
      input logic en, input logic [1:0] pc, input string tag);
    logic [31:0] expV;
    logic        expF;
    expV = legalize(modelReg, d, m, en, pc);
    expF = (expV != modelReg);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; hartMask = m; featWrEn = en; nextPcLow = pc;
    @(negedge clk);
    wrValid = 1'b0;
    check(cfgValue == expV, {tag, " value (R10)"}, cfgValue, expV);
    check(flushPulse == expF, {tag, " flush (R9)"}, {31'b0, flushPulse}, {31'b0, expF});
    modelReg = expV;
    @(negedge clk);
    check(flushPulse == 1'b0, {tag, " flush width R9"}, {31'b0, flushPulse}, 32'h0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    rst_n = 1'b0; wrValid = 1'b0; wrData = '0; hartMask = '1;
    featWrEn = 1'b1; nextPcLow = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    modelReg = RST_VAL;
    @(negedge clk);
    check(cfgValue == RST_VAL, "reset value R1", cfgValue, RST_VAL);
    check(flushPulse == 1'b0, "reset flush R1", {31'b0, flushPulse}, 32'h0);

    applyWrite(32'h0000_0100, '1, 1'b0, 2'b00, "locked R2");
    applyWrite(32'h0000_1020, '1, 1'b1, 2'b00, "no base R3");
    applyWrite(32'h0000_1110, '1, 1'b1, 2'b00, "embedded R4");
    applyWrite(32'h0000_1104, '1, 1'b1, 2'b00, "I M C R5");
    check(cfgValue == 32'h4000_1104, "I M C exact R5", cfgValue, 32'h4000_1104);
    applyWrite(32'h0000_1104, '1, 1'b1, 2'b00, "rewrite same R9");
    applyWrite(32'h0080_11A3, 32'hFFFF_EFFF, 1'b1, 2'b00, "unsupported R5");
    check(cfgValue == 32'h4000_0121, "unsupported exact R5", cfgValue, 32'h4000_0121);
    applyWrite(32'h0000_0108, '1, 1'b1, 2'b00, "D without F R6");
    applyWrite(32'h0000_0128, 32'hFFFF_FFDF, 1'b1, 2'b00, "F masked R6");
    applyWrite(32'h0000_0104, '1, 1'b1, 2'b10, "C misaligned R7");
    check(cfgValue[2] == 1'b0, "C cleared R7", cfgValue, cfgValue & ~32'h4);
    applyWrite(32'h0000_0104, '1, 1'b1, 2'b01, "C odd R7");
    applyWrite(32'h8014_112D, '1, 1'b1, 2'b00, "base field R8");
    check(cfgValue[31:30] == 2'b01, "base kept R8", cfgValue, 32'h4014112D);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] d, m;
      logic [1:0]  pc;
      logic        en;
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[8] = 1'b1;
      if ($urandom_range(0, 3) != 0) d[4] = 1'b0;
      m = $urandom | $urandom;
      en = ($urandom_range(0, 7) != 0);
      pc = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      applyWrite(d, m, en, pc, "random R5 R6 R7");
    end
    finishRun();
  end

endmodule